// File: doc/BRIEF.md
# Flash Program/Erase Status Read Multiplexer

This block forms the word a reader gets back from the flash address space while the program/erase engine owns the array. It sits between the array read path and the bus. For each read it decides whether the address falls on the word being programmed, or inside the block being erased, suspended or checked for protection. If so, it returns a status word in place of the array data. Otherwise it passes the array word through unchanged. The returned word is registered on the clock edge that samples the read strobe.

Software polls this word to follow an operation. Bit 7 is a polling bit that only shows its final value once the operation is over. Bit 6 and bit 2 flip on every status read, so two identical reads in a row mean the engine is done. Bit 5 is a sticky failure flag, and bit 3 shows whether the block-erase address window has closed. The block keeps three pieces of state: the toggle flip-flop, the sticky error flag, and a countdown that models the short status window after an erase of protected blocks.

Top module: `flash_status_mux`

## Requirements
- R1: After synchronous reset, rd_data is 0, the toggle state is 0 (so the first status read returns bit 6 = 0), the error flag is clear and no protected-block window is active.
- R2: A read with no status selection returns, on the next edge, the array_data sampled with the strobe. Without rd_strobe, rd_data holds its value.
- R3: With op_kind = 2'b01 (program), busy high and rd_addr equal to tgt_addr, bit 7 of the returned word is the inverse of prog_bit7. Reads at any other address pass array data.
- R4: Every status read returns the current toggle state in bit 6 and then inverts it. A susp_cmd pulse also inverts it. When a status read and a susp_cmd pulse fall on the same edge, the two inversions cancel.
- R5: With op_kind = 2'b10 (erase), busy high, suspend low and rd_addr in the same block as tgt_addr (equal address bits above BLK_BITS), the status word has bit 7 = 0 and bit 2 = toggle state. Bit 3 is 0 while win_open is high and 1 once it is low.
- R6: With op_kind = 2'b10 and suspend high, reads inside the target block return bit 7 = 1, bit 6 = 1, bit 3 = 1 and bit 2 = toggle state. Reads outside that block return array data.
- R7: An err_set pulse sets the sticky flag returned in bit 5. The flag stays set until an rd_reset pulse clears it, and set wins when both pulses arrive together. While the flag is set, status is still returned at the target even after busy falls.
- R8: A prot_start pulse opens a window of exactly PROT_CYCLES clock edges after the edge that samples it. In that window, reads inside the target block return status with bit 7 = 0 and bit 3 = 1. The first read after the window returns array data.
- R9: In every status word, bits 15:8, 4, 1 and 0 are 0. During a program, bit 3 and bit 2 are also 0.
- R10: Once busy is low and the error flag is clear, reads at the target return the array word, so bit 7 carries the true stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_kind | input | 2 | Engine operation: 00 idle, 01 program, 10 erase, 11 idle |
| busy | input | 1 | Engine is running the operation |
| prog_bit7 | input | 1 | Bit 7 of the word being programmed |
| err_set | input | 1 | Pulse: engine reports a failed operation |
| rd_reset | input | 1 | Pulse: read/reset command, clears the error flag |
| suspend | input | 1 | Erase is suspended |
| susp_cmd | input | 1 | Pulse: suspend or resume command accepted |
| win_open | input | 1 | Block-erase address window still open |
| prot_start | input | 1 | Pulse: erase was aimed at protected blocks only |
| tgt_addr | input | AW | Word being programmed, or an address in the block being erased |
| rd_addr | input | AW | Read address |
| rd_strobe | input | 1 | Read request, sampled on the clock edge |
| array_data | input | 16 | Word read from the array at rd_addr |
| rd_data | output | 16 | Returned read word |

## Verification
The bench drives the sequences that catch a misplaced address match. It reads one word away from the target during a program, and inside versus outside the erase block while suspended. A design that compares the wrong address bits returns status where array data belongs, or the reverse. It steps the toggle through back-to-back reads and a suspend command. An off-by-one inversion, or a toggle that also moves on pass-through reads, breaks the expected alternation. It reads at the last and first edge around the protected-block window, so a window one cycle too long or short shows up. It also checks that the error flag keeps status alive after busy falls, and that set beats clear when both arrive together.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'b00,
        OP_PROG  = 2'b01,
        OP_ERASE = 2'b10,
        OP_RSVD  = 2'b11
    } op_kind_e;

    typedef enum logic [2:0] {
        SM_PASS,
        SM_PROG,
        SM_ERASE,
        SM_SUSP,
        SM_PROT
    } smode_e;

    // Field positions are fixed: software decodes them.
    typedef struct packed {
        logic [7:0] rsv_hi;
        logic       poll;
        logic       tgl6;
        logic       fail;
        logic       rsv4;
        logic       win_done;
        logic       tgl2;
        logic [1:0] rsv_lo;
    } stat_word_t;

    localparam int unsigned WORD_W = $bits(stat_word_t);

    function automatic stat_word_t build_status(
        input smode_e m,
        input logic   b7,
        input logic   tg,
        input logic   er,
        input logic   win_open
    );
        stat_word_t s;
        s      = '0;
        s.fail = er;
        s.tgl6 = tg;
        unique case (m)
            SM_PROG: begin
                s.poll = ~b7;
            end
            SM_ERASE: begin
                s.poll     = 1'b0;
                s.win_done = ~win_open;
                s.tgl2     = tg;
            end
            SM_SUSP: begin
                s.poll     = 1'b1;
                s.tgl6     = 1'b1;
                s.win_done = 1'b1;
                s.tgl2     = tg;
            end
            SM_PROT: begin
                s.poll     = 1'b0;
                s.win_done = 1'b1;
                s.tgl2     = tg;
            end
            default: s = '0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/fsr_addr_match.sv
module fsr_addr_match #(
    parameter int unsigned AW       = 16,
    parameter int unsigned BLK_BITS = 8
) (
    input  logic [AW-1:0] rd_addr,
    input  logic [AW-1:0] tgt_addr,
    output logic          word_hit,
    output logic          blk_hit
);
    assign word_hit = (rd_addr == tgt_addr);

    generate
        if (BLK_BITS == 0) begin : g_word_blocks
            assign blk_hit = word_hit;
        end else if (BLK_BITS >= AW) begin : g_one_block
            assign blk_hit = 1'b1;
        end else begin : g_upper_cmp
            assign blk_hit = (rd_addr[AW-1:BLK_BITS] == tgt_addr[AW-1:BLK_BITS]);
        end
    endgenerate
endmodule

// File: rtl/fsr_mode_sel.sv
module fsr_mode_sel
    import fsr_pkg::*;
(
    input  logic [1:0] op_kind,
    input  logic       busy,
    input  logic       suspend,
    input  logic       err_q,
    input  logic       prot_active,
    input  logic       word_hit,
    input  logic       blk_hit,
    input  logic       rd_strobe,
    output smode_e     mode,
    output logic       status_rd
);
    op_kind_e op;
    logic     engaged;

    assign op      = op_kind_e'(op_kind);
    assign engaged = busy | err_q;

    // Priority: program word, suspended block, erasing block, protect window.
    always_comb begin
        mode = SM_PASS;
        if (op == OP_PROG && engaged && word_hit) begin
            mode = SM_PROG;
        end else if (op == OP_ERASE && suspend && blk_hit) begin
            mode = SM_SUSP;
        end else if (op == OP_ERASE && engaged && !suspend && blk_hit) begin
            mode = SM_ERASE;
        end else if (prot_active && blk_hit) begin
            mode = SM_PROT;
        end
    end

    assign status_rd = rd_strobe && (mode != SM_PASS);
endmodule

// File: rtl/fsr_flags.sv
module fsr_flags (
    input  logic clk,
    input  logic rst,
    input  logic status_rd,
    input  logic susp_cmd,
    input  logic err_set,
    input  logic rd_reset,
    output logic tgl_q,
    output logic err_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            tgl_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            tgl_q <= tgl_q ^ status_rd ^ susp_cmd;
            if (err_set) begin
                err_q <= 1'b1;
            end else if (rd_reset) begin
                err_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/fsr_prot_timer.sv
module fsr_prot_timer #(
    parameter int unsigned PROT_CYCLES = 100,
    localparam int unsigned CW = $clog2(PROT_CYCLES + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    output logic [CW-1:0] cnt,
    output logic          active
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= CW'(PROT_CYCLES);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign active = (cnt != '0);
endmodule

// File: rtl/flash_status_mux.sv
module flash_status_mux
    import fsr_pkg::*;
#(
    parameter int unsigned AW          = 16,
    parameter int unsigned BLK_BITS    = 8,
    parameter int unsigned PROT_CYCLES = 100
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    op_kind,
    input  logic          busy,
    input  logic          prog_bit7,
    input  logic          err_set,
    input  logic          rd_reset,
    input  logic          suspend,
    input  logic          susp_cmd,
    input  logic          win_open,
    input  logic          prot_start,
    input  logic [AW-1:0] tgt_addr,
    input  logic [AW-1:0] rd_addr,
    input  logic          rd_strobe,
    input  logic [15:0]   array_data,
    output logic [15:0]   rd_data
);
    localparam int unsigned CW = $clog2(PROT_CYCLES + 1);

    logic          word_hit;
    logic          blk_hit;
    logic          tgl_q;
    logic          err_q;
    logic          prot_active;
    logic [CW-1:0] prot_cnt;
    logic          status_rd;
    smode_e        mode;
    stat_word_t    stat;
    logic [WORD_W-1:0] next_word;

    fsr_addr_match #(.AW(AW), .BLK_BITS(BLK_BITS)) u_match (
        .rd_addr  (rd_addr),
        .tgt_addr (tgt_addr),
        .word_hit (word_hit),
        .blk_hit  (blk_hit)
    );

    fsr_prot_timer #(.PROT_CYCLES(PROT_CYCLES)) u_prot (
        .clk    (clk),
        .rst    (rst),
        .start  (prot_start),
        .cnt    (prot_cnt),
        .active (prot_active)
    );

    fsr_mode_sel u_sel (
        .op_kind     (op_kind),
        .busy        (busy),
        .suspend     (suspend),
        .err_q       (err_q),
        .prot_active (prot_active),
        .word_hit    (word_hit),
        .blk_hit     (blk_hit),
        .rd_strobe   (rd_strobe),
        .mode        (mode),
        .status_rd   (status_rd)
    );

    fsr_flags u_flags (
        .clk       (clk),
        .rst       (rst),
        .status_rd (status_rd),
        .susp_cmd  (susp_cmd),
        .err_set   (err_set),
        .rd_reset  (rd_reset),
        .tgl_q     (tgl_q),
        .err_q     (err_q)
    );

    assign stat      = build_status(mode, prog_bit7, tgl_q, err_q, win_open);
    assign next_word = (mode == SM_PASS) ? array_data : stat;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_strobe) begin
            rd_data <= next_word;
        end
    end
endmodule

// File: rtl/flash_status_mux_chk.sv
module flash_status_mux_chk #(
    parameter int unsigned AW          = 16,
    parameter int unsigned PROT_CYCLES = 100,
    localparam int unsigned CW = $clog2(PROT_CYCLES + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic [1:0]    op_kind,
    input logic          busy,
    input logic          prog_bit7,
    input logic          err_set,
    input logic          rd_reset,
    input logic          susp_cmd,
    input logic [AW-1:0] tgt_addr,
    input logic [AW-1:0] rd_addr,
    input logic          rd_strobe,
    input logic [15:0]   array_data,
    input logic [15:0]   rd_data,
    input logic          tgl_q,
    input logic          err_q,
    input logic [CW-1:0] prot_cnt
);
    logic prog_hit;
    assign prog_hit = rd_strobe && (op_kind == 2'b01) && busy && (rd_addr == tgt_addr);

    a_r2_pass: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && op_kind == 2'b00 && prot_cnt == '0) |=> rd_data == $past(array_data));

    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        !rd_strobe |=> $stable(rd_data));

    a_r3_poll_inverted: assert property (@(posedge clk) disable iff (rst)
        prog_hit |=> rd_data[7] == !$past(prog_bit7));

    a_r4_toggle_flips: assert property (@(posedge clk) disable iff (rst)
        (prog_hit && !susp_cmd) |=> tgl_q != $past(tgl_q));

    a_r7_err_set: assert property (@(posedge clk) disable iff (rst)
        err_set |=> err_q);

    a_r7_err_sticky: assert property (@(posedge clk) disable iff (rst)
        (err_q && !rd_reset) |=> err_q);

    a_r7_err_clear: assert property (@(posedge clk) disable iff (rst)
        (rd_reset && !err_set) |=> !err_q);

    a_r8_window_bound: assert property (@(posedge clk) disable iff (rst)
        prot_cnt <= CW'(PROT_CYCLES));

    a_r9_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        prog_hit |=> (rd_data[15:8] == 8'h00 && rd_data[4] == 1'b0 &&
                      rd_data[3:0] == 4'h0));
endmodule

bind flash_status_mux flash_status_mux_chk #(
    .AW          (AW),
    .PROT_CYCLES (PROT_CYCLES)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .op_kind    (op_kind),
    .busy       (busy),
    .prog_bit7  (prog_bit7),
    .err_set    (err_set),
    .rd_reset   (rd_reset),
    .susp_cmd   (susp_cmd),
    .tgt_addr   (tgt_addr),
    .rd_addr    (rd_addr),
    .rd_strobe  (rd_strobe),
    .array_data (array_data),
    .rd_data    (rd_data),
    .tgl_q      (tgl_q),
    .err_q      (err_q),
    .prot_cnt   (prot_cnt)
);

// File: tb/flash_status_mux_bench.sv
module flash_status_mux_bench;
    localparam int AW   = 16;
    localparam int BB   = 8;
    localparam int PROT = 20;
    localparam int WD   = 100000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    op_kind = 2'b00;
    logic          busy = 1'b0, prog_bit7 = 1'b0, err_set = 1'b0, rd_reset = 1'b0;
    logic          suspend = 1'b0, susp_cmd = 1'b0, win_open = 1'b0, prot_start = 1'b0;
    logic [AW-1:0] tgt_addr = '0, rd_addr = '0;
    logic          rd_strobe = 1'b0;
    logic [15:0]   array_data = '0;
    logic [15:0]   rd_data;

    int  n_chk = 0, n_fail = 0, cyc = 0;
    bit  done = 1'b0;
    logic m_tgl = 1'b0, m_err = 1'b0, m_prot = 1'b0;

    flash_status_mux #(.AW(AW), .BLK_BITS(BB), .PROT_CYCLES(PROT)) u_flash_status_mux (
        .clk(clk), .rst(rst), .op_kind(op_kind), .busy(busy), .prog_bit7(prog_bit7),
        .err_set(err_set), .rd_reset(rd_reset), .suspend(suspend), .susp_cmd(susp_cmd),
        .win_open(win_open), .prot_start(prot_start), .tgt_addr(tgt_addr),
        .rd_addr(rd_addr), .rd_strobe(rd_strobe), .array_data(array_data),
        .rd_data(rd_data)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WD && !done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run hung, actual cycles %0d expected below %0d", cyc, WD);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // 0 pass, 1 program, 2 erase, 3 suspended, 4 protect window
    function automatic int exp_mode(input logic [AW-1:0] a);
        logic blk;
        blk = (a[AW-1:BB] == tgt_addr[AW-1:BB]);
        if (op_kind == 2'b01 && (busy || m_err) && a == tgt_addr) return 1;
        if (op_kind == 2'b10 && suspend && blk) return 3;
        if (op_kind == 2'b10 && (busy || m_err) && blk) return 2;
        if (m_prot && blk) return 4;
        return 0;
    endfunction

    function automatic logic [15:0] exp_word(input int m, input logic [15:0] arr);
        logic [15:0] w;
        w = 16'h0000;
        w[5] = m_err;
        w[6] = m_tgl;
        case (m)
            1: w[7] = ~prog_bit7;
            2: begin w[7] = 1'b0; w[3] = ~win_open; w[2] = m_tgl; end
            3: begin w[7] = 1'b1; w[6] = 1'b1; w[3] = 1'b1; w[2] = m_tgl; end
            4: begin w[7] = 1'b0; w[3] = 1'b1; w[2] = m_tgl; end
            default: w = arr;
        endcase
        return w;
    endfunction

    task automatic do_read(input logic [AW-1:0] a, input logic [15:0] arr, input string req);
        logic [15:0] e;
        int m;
        rd_addr = a;
        array_data = arr;
        rd_strobe = 1'b1;
        m = exp_mode(a);
        e = exp_word(m, arr);
        if (m != 0) m_tgl = ~m_tgl;
        @(negedge clk);
        rd_strobe = 1'b0;
        chk(req, rd_data, e);
    endtask

    task automatic pulse_err();
        err_set = 1'b1; m_err = 1'b1; @(negedge clk); err_set = 1'b0;
    endtask

    task automatic pulse_rdrst();
        rd_reset = 1'b1; m_err = 1'b0; @(negedge clk); rd_reset = 1'b0;
    endtask

    task automatic pulse_susp();
        susp_cmd = 1'b1; m_tgl = ~m_tgl; @(negedge clk); susp_cmd = 1'b0;
    endtask

    initial begin
        logic [15:0] prev;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset value", rd_data, 16'h0000);

        // R1: first status read shows bit 6 = 0
        op_kind = 2'b01; busy = 1'b1; prog_bit7 = 1'b0; tgt_addr = 16'h1234;
        do_read(16'h1234, 16'hFFFF, "R1 first toggle 0 / R3 poll");
        do_read(16'h1234, 16'hFFFF, "R4 second read toggles");
        do_read(16'h1235, 16'hA5A5, "R3 other address passes");

        // R2: hold without strobe
        prev = rd_data;
        array_data = 16'h0F0F;
        repeat (3) @(negedge clk);
        chk("R2 hold without strobe", rd_data, prev);

        // Random mix (R2 R3 R5 R6 R9)
        for (int i = 0; i < 300; i++) begin
            logic [AW-1:0] a;
            int sel;
            op_kind   = 2'($urandom_range(0, 2));
            busy      = 1'($urandom);
            prog_bit7 = 1'($urandom);
            win_open  = 1'($urandom);
            suspend   = (op_kind == 2'b10) ? 1'($urandom) : 1'b0;
            tgt_addr  = 16'($urandom);
            sel = $urandom_range(0, 2);
            if (sel == 0) a = tgt_addr;
            else if (sel == 1) a = {tgt_addr[AW-1:BB], 8'($urandom)};
            else a = 16'($urandom);
            do_read(a, 16'($urandom), "R9 random status/pass mix (R2 R3 R5 R6)");
        end

        // R10: program done returns true stored word
        op_kind = 2'b01; busy = 1'b0; prog_bit7 = 1'b1; tgt_addr = 16'h0400;
        do_read(16'h0400, 16'h00C3, "R10 completed program returns array word");

        // R5: erase with window open then closed
        op_kind = 2'b10; busy = 1'b1; suspend = 1'b0; win_open = 1'b1; tgt_addr = 16'h3300;
        do_read(16'h3310, 16'hFFFF, "R5 erase window open");
        win_open = 1'b0;
        do_read(16'h33FF, 16'hFFFF, "R5 erase window closed");
        do_read(16'h3400, 16'h1111, "R5 outside erase block passes");

        // R4/R6: suspend command toggles, suspended block reads
        pulse_susp();
        suspend = 1'b1;
        do_read(16'h3301, 16'hFFFF, "R6 suspended block status");
        do_read(16'h3301, 16'hFFFF, "R6 suspended bit2 toggles");
        do_read(16'h7700, 16'h5A5A, "R6 other block readable in suspend");
        suspend = 1'b0;
        pulse_susp();
        do_read(16'h3302, 16'hFFFF, "R4 resume toggles bit 6");
        busy = 1'b0;
        do_read(16'h3302, 16'hFFFF, "R10 erase done returns ones");

        // R7: sticky error
        op_kind = 2'b01; busy = 1'b1; prog_bit7 = 1'b0; tgt_addr = 16'h0222;
        pulse_err();
        busy = 1'b0;
        do_read(16'h0222, 16'h0000, "R7 error keeps status after busy falls");
        do_read(16'h0222, 16'h0000, "R7 error stays set");
        pulse_rdrst();
        do_read(16'h0222, 16'h0055, "R7 read/reset clears error");
        busy = 1'b1;
        err_set = 1'b1; rd_reset = 1'b1; m_err = 1'b1;
        @(negedge clk);
        err_set = 1'b0; rd_reset = 1'b0;
        do_read(16'h0222, 16'h0000, "R7 set wins over clear");
        pulse_rdrst();
        busy = 1'b0;

        // R8: protected-block window length
        op_kind = 2'b10; busy = 1'b0; tgt_addr = 16'h5500;
        prot_start = 1'b1;
        @(negedge clk);
        prot_start = 1'b0;
        m_prot = 1'b1;
        repeat (PROT - 1) @(negedge clk);
        do_read(16'h5510, 16'h7777, "R8 last edge of protect window");
        m_prot = 1'b0;
        do_read(16'h5510, 16'h7777, "R8 array after protect window");
        op_kind = 2'b00;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule